// File: doc/BRIEF.md
# Raster Panel Timing Generator

This block produces the timing skeleton for a parallel TFT panel: a divided pixel clock with its clock enable, a line sync, a frame sync, a data-enable window with the current pixel column and row, and a single-cycle end-of-frame pulse. The geometry comes from coded configuration fields. Line width is given in units of 16 pixels. Height is given as a line count minus one. Porches and sync widths are given as counts minus one. Each of the pixel clock, line sync and frame sync can be inverted on its own.

Software loads every configuration field while the engine is idle and then sets the run-enable input. The engine starts a frame at once, with line sync and frame sync both active. It keeps running frames until run-enable is cleared. It then completes the frame in progress and returns to the idle levels. Pixel fetch and the electrical panel interface sit outside this block.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, and whenever the engine is idle, de_o is 0, eof_o is 0, x_o and y_o are 0, and pclk_o, hsync_o and vsync_o rest at the levels of inv_pclk_i, inv_hs_i and inv_vs_i.
- R2: The pixel period lasts E core cycles, where E is pix_div_i, or 2 when pix_div_i is below 2. pix_ce_o pulses once per period. Without inversion, pclk_o is high for E - floor(E/2) cycles of each period.
- R3: An active line holds (ppl_code_i + 1) * 16 pixels. With the default WIDE_PPL = 1, all 7 bits of ppl_code_i are used, giving at most 2048 pixels. With WIDE_PPL = 0, bit 6 is ignored, giving at most 1024 pixels.
- R4: A frame holds lpp_code_i + 1 active lines, where lpp_code_i is 11 bits wide.
- R5: Each line runs in this order: line sync for hsw_code_i + 1 pixels, back porch for hbp_code_i + 1 pixels, the active pixels, then front porch for hfp_code_i + 1 pixels.
- R6: Each frame runs the same order counted in lines: frame sync for vsw_code_i + 1 lines, back porch for vbp_code_i + 1 lines, the active lines, then front porch for vfp_code_i + 1 lines.
- R7: Setting inv_pclk_i, inv_hs_i or inv_vs_i to 1 inverts pclk_o, hsync_o or vsync_o respectively. Without inversion, both syncs are active high.
- R8: While de_o is 1, x_o counts 0 to width-1 across the line and y_o counts 0 to height-1 down the frame.
- R9: eof_o is high for exactly one core cycle per frame. That cycle is the first cycle after the last pixel period of the last active line, and de_o is 0 in it.
- R10: One cycle after raster_en_i rises from idle, both syncs are active and a frame is in progress. Clearing raster_en_i lets the current frame finish, including its eof_o pulse, and then the engine stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raster_en_i | input | 1 | Run enable for the engine |
| pix_div_i | input | 8 | Core cycles per pixel period |
| ppl_code_i | input | 7 | Line width in units of 16 pixels, minus one |
| lpp_code_i | input | 11 | Active lines minus one |
| hsw_code_i | input | 6 | Line sync width minus one, in pixels |
| hbp_code_i | input | 8 | Line back porch minus one, in pixels |
| hfp_code_i | input | 8 | Line front porch minus one, in pixels |
| vsw_code_i | input | 6 | Frame sync width minus one, in lines |
| vbp_code_i | input | 8 | Frame back porch minus one, in lines |
| vfp_code_i | input | 8 | Frame front porch minus one, in lines |
| inv_pclk_i | input | 1 | Invert the pixel clock |
| inv_hs_i | input | 1 | Invert the line sync |
| inv_vs_i | input | 1 | Invert the frame sync |
| pclk_o | output | 1 | Pixel clock to the panel |
| pix_ce_o | output | 1 | One-cycle pulse at the end of each pixel period |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Active-data window |
| x_o | output | 12 | Column of the current active pixel |
| y_o | output | 12 | Row of the current active pixel |
| eof_o | output | 1 | End-of-frame pulse |

## Verification
The syncs, de_o and the positions are decoded directly from the counter registers. They therefore change in the cycle after the clock edge that moves a counter, and the engine's first state appears one cycle after raster_en_i is set. eof_o is registered from the final pixel step of the last active line, so it is due in the cycle that follows that step. The checks sample on the falling clock edge. They measure whole frames from one eof_o to the next, so each duration compares with a closed product of line total, frame total and divisor, and none depends on guessing the phase of a single edge. After a disable, the bench allows a full frame plus margin before it checks the idle levels.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int DIV_W   = 8;
  localparam int PPL_W   = 7;
  localparam int LPP_W   = 11;
  localparam int SYNC_W  = 6;
  localparam int PORCH_W = 8;
  localparam int PX_UNIT_LOG2 = 4;
  // widest line: 64 + 256 + 2048 + 256 = 2624 -> 12 bits
  localparam int CNT_W   = 12;
endpackage

// File: rtl/rt_clkdiv.sv
module rt_clkdiv
  import rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             inv_i,
  output logic             tick_o,
  output logic             pclk_o
);
  logic [DIV_W-1:0] eff_div;
  logic [DIV_W-1:0] half_div;
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign eff_div  = (div_i < DIV_W'(2)) ? DIV_W'(2) : div_i;
  assign half_div = eff_div >> 1;
  assign at_end   = (cnt_q == eff_div - DIV_W'(1));

  always_comb begin
    if (!run_i || at_end) cnt_d = '0;
    else                  cnt_d = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = run_i & at_end;
  assign pclk_o = (run_i & (cnt_q >= half_div)) ^ inv_i;
endmodule

// File: rtl/rt_axis.sv
module rt_axis
  import rt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] sync_len_i,
  input  logic [CNT_W-1:0] bp_len_i,
  input  logic [CNT_W-1:0] act_len_i,
  input  logic [CNT_W-1:0] fp_len_i,
  output logic             last_o,
  output logic             sync_o,
  output logic             act_o,
  output logic [CNT_W-1:0] pos_o
);
  logic [CNT_W-1:0] act_start, act_stop, total;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign act_start = sync_len_i + bp_len_i;
  assign act_stop  = act_start + act_len_i;
  assign total     = act_stop + fp_len_i;

  assign last_o = (cnt_q == total - CNT_W'(1));
  assign sync_o = (cnt_q < sync_len_i);
  assign act_o  = (cnt_q >= act_start) && (cnt_q < act_stop);
  assign pos_o  = act_o ? (cnt_q - act_start) : '0;

  always_comb begin
    if (clr_i)                 cnt_d = '0;
    else if (step_i && last_o) cnt_d = '0;
    else if (step_i)           cnt_d = cnt_q + CNT_W'(1);
    else                       cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rt_pkg::*;
#(
  parameter bit WIDE_PPL = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               raster_en_i,
  input  logic [DIV_W-1:0]   pix_div_i,
  input  logic [PPL_W-1:0]   ppl_code_i,
  input  logic [LPP_W-1:0]   lpp_code_i,
  input  logic [SYNC_W-1:0]  hsw_code_i,
  input  logic [PORCH_W-1:0] hbp_code_i,
  input  logic [PORCH_W-1:0] hfp_code_i,
  input  logic [SYNC_W-1:0]  vsw_code_i,
  input  logic [PORCH_W-1:0] vbp_code_i,
  input  logic [PORCH_W-1:0] vfp_code_i,
  input  logic               inv_pclk_i,
  input  logic               inv_hs_i,
  input  logic               inv_vs_i,
  output logic               pclk_o,
  output logic               pix_ce_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [CNT_W-1:0]   x_o,
  output logic [CNT_W-1:0]   y_o,
  output logic               eof_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // width variant
  logic [PPL_W-1:0] ppl_used;
  generate
    if (WIDE_PPL) begin : g_wide_ppl
      assign ppl_used = ppl_code_i;
    end else begin : g_narrow_ppl
      assign ppl_used = {1'b0, ppl_code_i[PPL_W-2:0]};
    end
  endgenerate

  // decoded lengths
  logic [CNT_W-1:0] h_sync_len, h_bp_len, h_act_len, h_fp_len;
  logic [CNT_W-1:0] v_sync_len, v_bp_len, v_act_len, v_fp_len;

  assign h_sync_len = CNT_W'(hsw_code_i) + ONE;
  assign h_bp_len   = CNT_W'(hbp_code_i) + ONE;
  assign h_act_len  = (CNT_W'(ppl_used) + ONE) << PX_UNIT_LOG2;
  assign h_fp_len   = CNT_W'(hfp_code_i) + ONE;
  assign v_sync_len = CNT_W'(vsw_code_i) + ONE;
  assign v_bp_len   = CNT_W'(vbp_code_i) + ONE;
  assign v_act_len  = CNT_W'(lpp_code_i) + ONE;
  assign v_fp_len   = CNT_W'(vfp_code_i) + ONE;

  // run control
  logic run_q, run_d;
  logic tick;
  logic h_last, h_sync, h_act;
  logic v_last, v_sync, v_act;
  logic [CNT_W-1:0] h_pos, v_pos;
  logic line_wrap, frame_end, last_act_line;
  logic eof_q, eof_d;

  rt_clkdiv u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .run_i  (run_q),
    .div_i  (pix_div_i),
    .inv_i  (inv_pclk_i),
    .tick_o (tick),
    .pclk_o (pclk_o)
  );

  rt_axis u_h (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .clr_i      (~run_q),
    .step_i     (tick),
    .sync_len_i (h_sync_len),
    .bp_len_i   (h_bp_len),
    .act_len_i  (h_act_len),
    .fp_len_i   (h_fp_len),
    .last_o     (h_last),
    .sync_o     (h_sync),
    .act_o      (h_act),
    .pos_o      (h_pos)
  );

  assign line_wrap = tick & h_last;

  rt_axis u_v (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .clr_i      (~run_q),
    .step_i     (line_wrap),
    .sync_len_i (v_sync_len),
    .bp_len_i   (v_bp_len),
    .act_len_i  (v_act_len),
    .fp_len_i   (v_fp_len),
    .last_o     (v_last),
    .sync_o     (v_sync),
    .act_o      (v_act),
    .pos_o      (v_pos)
  );

  assign frame_end     = line_wrap & v_last;
  assign last_act_line = v_act && (v_pos == v_act_len - ONE);

  always_comb begin
    if (!run_q) run_d = raster_en_i;
    else        run_d = !(frame_end && !raster_en_i);
    eof_d = line_wrap & last_act_line;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      run_q <= 1'b0;
      eof_q <= 1'b0;
    end else begin
      run_q <= run_d;
      eof_q <= eof_d;
    end
  end

  assign pix_ce_o = tick;
  assign hsync_o  = (run_q & h_sync) ^ inv_hs_i;
  assign vsync_o  = (run_q & v_sync) ^ inv_vs_i;
  assign de_o     = run_q & h_act & v_act;
  assign x_o      = de_o ? h_pos : '0;
  assign y_o      = de_o ? v_pos : '0;
  assign eof_o    = eof_q;
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
  import rt_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pix_ce_o,
  input logic             hsync_o,
  input logic             vsync_o,
  input logic             de_o,
  input logic             eof_o,
  input logic             inv_hs_i,
  input logic             inv_vs_i,
  input logic [PPL_W-1:0] ppl_code_i,
  input logic [CNT_W-1:0] x_o
);
  a_r9_eof_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);

  a_r9_eof_outside_de: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !de_o);

  a_r5_de_clear_of_hsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !(hsync_o ^ inv_hs_i));

  a_r6_de_clear_of_vsync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> !(vsync_o ^ inv_vs_i));

  a_r8_x_starts_at_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(de_o) |-> (x_o == '0));

  a_r3_x_within_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> ({1'b0, x_o} < ((CNT_W+1)'(ppl_code_i) + 1) * 16));

  a_r2_ce_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ce_o |=> !pix_ce_o);
endmodule

bind raster_timing_gen raster_timing_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pix_ce_o   (pix_ce_o),
  .hsync_o    (hsync_o),
  .vsync_o    (vsync_o),
  .de_o       (de_o),
  .eof_o      (eof_o),
  .inv_hs_i   (inv_hs_i),
  .inv_vs_i   (inv_vs_i),
  .ppl_code_i (ppl_code_i),
  .x_o        (x_o)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;
  import rt_pkg::*;

  typedef struct packed {
    logic [7:0]  div;
    logic [6:0]  ppl;
    logic [10:0] lpp;
    logic [5:0]  hsw;
    logic [7:0]  hbp;
    logic [7:0]  hfp;
    logic [5:0]  vsw;
    logic [7:0]  vbp;
    logic [7:0]  vfp;
    logic        ip;
    logic        ih;
    logic        iv;
  } cfg_t;

  localparam int NROWS = 5;
  localparam cfg_t TBL [NROWS] = '{
    '{8'd2, 7'd0,    11'd3, 6'd1, 8'd2, 8'd1, 6'd0, 8'd1, 8'd0, 1'b0, 1'b0, 1'b0},
    '{8'd3, 7'd1,    11'd2, 6'd0, 8'd0, 8'd0, 6'd1, 8'd0, 8'd2, 1'b1, 1'b1, 1'b1},
    '{8'd0, 7'd0,    11'd0, 6'd3, 8'd1, 8'd2, 6'd0, 8'd0, 8'd0, 1'b0, 1'b1, 1'b0},
    '{8'd1, 7'h40,   11'd1, 6'd0, 8'd0, 8'd0, 6'd0, 8'd0, 8'd0, 1'b1, 1'b0, 1'b1},
    '{8'd5, 7'd2,    11'd4, 6'd2, 8'd3, 8'd4, 6'd2, 8'd1, 8'd1, 1'b0, 1'b0, 1'b1}
  };

  logic clk_i = 1'b0;
  logic rst_ni;
  logic raster_en_i;
  cfg_t cur;
  logic pclk_o, pix_ce_o, hsync_o, vsync_o, de_o, eof_o;
  logic [CNT_W-1:0] x_o, y_o;

  int n_chk = 0;
  int n_err = 0;
  int wd_cnt = 0;

  always #5 clk_i = ~clk_i;

  raster_timing_gen dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .raster_en_i (raster_en_i),
    .pix_div_i   (cur.div),
    .ppl_code_i  (cur.ppl),
    .lpp_code_i  (cur.lpp),
    .hsw_code_i  (cur.hsw),
    .hbp_code_i  (cur.hbp),
    .hfp_code_i  (cur.hfp),
    .vsw_code_i  (cur.vsw),
    .vbp_code_i  (cur.vbp),
    .vfp_code_i  (cur.vfp),
    .inv_pclk_i  (cur.ip),
    .inv_hs_i    (cur.ih),
    .inv_vs_i    (cur.iv),
    .pclk_o      (pclk_o),
    .pix_ce_o    (pix_ce_o),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .x_o         (x_o),
    .y_o         (y_o),
    .eof_o       (eof_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  always @(posedge clk_i) begin
    wd_cnt++;
    if (wd_cnt > 150000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd_cnt);
      finish_run();
    end
  end

  task automatic check_idle(input string req);
    check({req, " de"},    int'(de_o), 0);
    check({req, " eof"},   int'(eof_o), 0);
    check({req, " x"},     int'(x_o), 0);
    check({req, " y"},     int'(y_o), 0);
    check({req, " hsync"}, int'(hsync_o), int'(cur.ih));
    check({req, " vsync"}, int'(vsync_o), int'(cur.iv));
    check({req, " pclk"},  int'(pclk_o), int'(cur.ip));
  endtask

  initial begin
    cur = TBL[0];
    raster_en_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check_idle("R1 reset");

    for (int r = 0; r < NROWS; r++) begin
      int eff, px, lines, htot, vtot, frame, pc_per;
      int cyc, de_n, hs_n, vs_n, pc_n, mx, my, eof_n;
      cur = TBL[r];
      eff   = (int'(cur.div) < 2) ? 2 : int'(cur.div);
      px    = (int'(cur.ppl) + 1) * 16;
      lines = int'(cur.lpp) + 1;
      htot  = int'(cur.hsw) + 1 + int'(cur.hbp) + 1 + px + int'(cur.hfp) + 1;
      vtot  = int'(cur.vsw) + 1 + int'(cur.vbp) + 1 + lines + int'(cur.vfp) + 1;
      frame = htot * vtot * eff;
      pc_per = cur.ip ? (eff / 2) : (eff - eff / 2);

      @(negedge clk_i);
      check_idle("R1 idle levels with inversion");
      raster_en_i = 1'b1;
      @(negedge clk_i);
      // R10: engine starts with both syncs active
      check("R10 hsync active at start", int'(hsync_o ^ cur.ih), 1);
      check("R10 vsync active at start", int'(vsync_o ^ cur.iv), 1);

      // measure one full frame from eof to eof
      while (!eof_o) @(negedge clk_i);
      cyc = 0; de_n = 0; hs_n = 0; vs_n = 0; pc_n = 0; mx = 0; my = 0;
      do begin
        cyc++;
        if (de_o) begin
          de_n++;
          if (int'(x_o) > mx) mx = int'(x_o);
          if (int'(y_o) > my) my = int'(y_o);
        end
        if (hsync_o ^ cur.ih) hs_n++;
        if (vsync_o ^ cur.iv) vs_n++;
        if (pclk_o) pc_n++;
        @(negedge clk_i);
      end while (!eof_o);

      check("R5 R6 R9 frame period", cyc, frame);
      check("R3 R4 active cycles", de_n, px * lines * eff);
      check("R5 R7 line sync cycles", hs_n, (int'(cur.hsw) + 1) * eff * vtot);
      check("R6 R7 frame sync cycles", vs_n, (int'(cur.vsw) + 1) * htot * eff);
      check("R2 R7 pixel clock high cycles", pc_n, htot * vtot * pc_per);
      check("R8 last column", mx, px - 1);
      check("R8 last row", my, lines - 1);

      // R10: disable early in a frame, the frame completes then stops
      while (!(vsync_o ^ cur.iv)) @(negedge clk_i);
      repeat (3) @(negedge clk_i);
      raster_en_i = 1'b0;
      eof_n = 0; de_n = 0;
      for (int k = 0; k < frame + 20; k++) begin
        @(negedge clk_i);
        if (eof_o) eof_n++;
        if (de_o) de_n++;
      end
      check("R10 eof pulses after disable", eof_n, 1);
      check("R10 active cycles after disable", de_n, px * lines * eff);
      check_idle("R10 idle after disable");
    end

    finish_run();
  end
endmodule